// File: doc/BRIEF.md
# Two-Wire Four-Phase TAP Link Master

This block drives a test access port over a two-wire link: one clock line, plus one data line that both sides share. Each TAP cycle is spread over four link clocks. On the first clock the master puts TDI on the data line. On the second it puts TMS there. On the third and fourth it lets go of the line so that the target can return TDO. The master samples TDO once per TAP cycle and gathers the samples into a response word.

A caller starts one of four operations through a valid/ready request port:
- a TMS-only mode entry sequence;
- an instruction-register shift;
- a data-register transfer;
- a fast data transfer, whose first returned bit is a processor-access flag.

`busy` stays high for the whole operation. A one-cycle `done` pulse marks the end, and at that point the response outputs are valid. They hold until the next `done`. The link clock period is set by the `cfg_div` value, which is latched when a request is accepted. The master never retries an operation on its own, whatever comes back. Any retry policy belongs to the caller.

Top module: `tap2w_master`

## Requirements
- R1: Every link clock lasts 2*(cfg_div+1) system cycles. It is high for the first cfg_div+1 cycles and low for the rest. Each TAP cycle takes exactly four link clocks, with no gaps, so an operation of N TAP cycles produces exactly 4*N link clock rising edges.
- R2: `lnk_oe` is high during the first and second link clocks of a TAP cycle, which carry TDI and TMS. It is low during the third and fourth.
- R3: `lnk_dout` and `lnk_oe` change only while the link clock rises. They hold their value across each falling edge.
- R4: TDO is taken from `lnk_din` at the falling edge of the third link clock of each TAP cycle. The value on the line during the fourth link clock is not used.
- R5: Mode operation (`req_op`=0) runs 6 TAP cycles. TMS is 1,1,1,1,1,0 in time order and TDI is 0 throughout. `rsp_err` is 1 if any of the 6 TDO samples is 1. For this operation `rsp_data` and `rsp_flag` are 0.
- R6: Instruction operation (`req_op`=1) runs IW+6 TAP cycles:
  - a header with TMS 1,1,0,0 and TDI 0;
  - IW cycles that shift `req_bits[IW-1:0]` LSB first, with TMS 0 on every cycle except the last, which has TMS 1;
  - a footer with TMS 1,0 and TDI 0.
  
  `rsp_data[i]` is the TDO of shift cycle i. The TDO of the last header cycle is ignored.
- R7: Data operation (`req_op`=2) runs DW+5 TAP cycles:
  - a header with TMS 1,0,0 and TDI 0;
  - DW cycles that shift `req_bits` LSB first, with TMS 1 only on the MSB;
  - a footer with TMS 1,0.
  
  `rsp_data[0]` is the TDO of the last header cycle, and `rsp_data[i]` is the TDO of shift cycle i-1. The TDO of the final shift cycle is ignored.
- R8: Fast data operation (`req_op`=3) produces the same link sequence as R7. `rsp_flag` is the TDO of the last header cycle, and `rsp_data[i]` is the TDO of shift cycle i. The operation runs exactly once whatever the flag value.
- R9: `req_ready` equals not `busy`. A request is taken when `req_valid` and `req_ready` are both high, and `busy` rises on the next cycle. Requests made while busy are ignored. `done` pulses for one cycle, in the cycle where `busy` falls.
- R10: During reset and while idle, `lnk_clk`, `lnk_oe` and `lnk_dout` are low. `busy` and `done` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIVW | Half-period of the link clock minus one, in system cycles |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | Operation: 0 mode, 1 instruction, 2 data, 3 fast data |
| req_bits | input | DW | Bits to shift, LSB first (instruction uses the low IW bits) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Captured TDO word |
| rsp_flag | output | 1 | Processor-access flag of a fast data transfer |
| rsp_err | output | 1 | A nonzero TDO was seen during the mode sequence |
| lnk_clk | output | 1 | Link clock |
| lnk_dout | output | 1 | Data line value driven by the master |
| lnk_oe | output | 1 | Data line output enable |
| lnk_din | input | 1 | Data line value seen by the master |

## Verification
If the phase counter is off, `lnk_oe` is high on the wrong link clock within one TAP cycle, and TDI and TMS swap places within the first four link clocks of an operation. If the TAP cycle counter is wrong, the operation has the wrong number of link clocks or the MSB carries TMS 1 at the wrong place; either shows at `done`. If the capture window is off by one, `rsp_data` comes out shifted, or picks up the inverted value that the target model drives during the fourth clock. That error shows on the first transfer with a nonuniform TDO pattern.

// File: rtl/tap2w_pkg.sv
package tap2w_pkg;

    typedef enum logic [1:0] {
        OP_MODE  = 2'd0,
        OP_INSTR = 2'd1,
        OP_DATA  = 2'd2,
        OP_FAST  = 2'd3
    } tw_op_e;

    localparam int MODE_CYC = 6;
    localparam int IR_HDR   = 4;
    localparam int DR_HDR   = 3;
    localparam int FOOT_CYC = 2;

    // number of TAP cycles in an operation
    function automatic int seq_len(tw_op_e op, int iw, int dw);
        int r;
        case (op)
            OP_MODE:  r = MODE_CYC;
            OP_INSTR: r = IR_HDR + iw + FOOT_CYC;
            default:  r = DR_HDR + dw + FOOT_CYC;
        endcase
        return r;
    endfunction

    // TMS value for TAP cycle k
    function automatic logic seq_tms(tw_op_e op, int k, int iw, int dw);
        logic r;
        r = 1'b0;
        case (op)
            OP_MODE:  r = (k < 5);
            OP_INSTR: begin
                if (k < 2)                 r = 1'b1;
                else if (k < IR_HDR)       r = 1'b0;
                else if (k < IR_HDR + iw)  r = (k == IR_HDR + iw - 1);
                else                       r = (k == IR_HDR + iw);
            end
            default: begin
                if (k == 0)                r = 1'b1;
                else if (k < DR_HDR)       r = 1'b0;
                else if (k < DR_HDR + dw)  r = (k == DR_HDR + dw - 1);
                else                       r = (k == DR_HDR + dw);
            end
        endcase
        return r;
    endfunction

    // TDI value for TAP cycle k
    function automatic logic seq_tdi(tw_op_e op, int k, int iw, int dw, logic [31:0] bits);
        logic r;
        int   j;
        r = 1'b0;
        case (op)
            OP_MODE:  r = 1'b0;
            OP_INSTR: begin
                j = k - IR_HDR;
                if (j >= 0 && j < iw) r = bits[j[4:0]];
            end
            default: begin
                j = k - DR_HDR;
                if (j >= 0 && j < dw) r = bits[j[4:0]];
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tap2w_phase.sv
module tap2w_phase #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [DIVW-1:0] div_i,
    input  logic            last_i,
    output logic            lnk_clk_o,
    output logic [1:0]      ph_o,
    output logic            fall_o,
    output logic            end_o
);

    typedef struct packed {
        logic            run;
        logic [DIVW-1:0] div;
        logic [DIVW-1:0] hcnt;
        logic            half;
        logic [1:0]      ph;
        logic            lclk;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        hit    = st_q.run && (st_q.hcnt == st_q.div);
        fall_o = hit && !st_q.half;
        end_o  = hit && st_q.half;
        st_d   = st_q;
        if (start_i) begin
            st_d.run  = 1'b1;
            st_d.div  = div_i;
            st_d.hcnt = '0;
            st_d.half = 1'b0;
            st_d.ph   = 2'd0;
            st_d.lclk = 1'b1;
        end else if (st_q.run) begin
            if (hit) begin
                st_d.hcnt = '0;
                if (!st_q.half) begin
                    st_d.half = 1'b1;
                    st_d.lclk = 1'b0;
                end else begin
                    st_d.half = 1'b0;
                    st_d.ph   = st_q.ph + 2'd1;
                    if (st_q.ph == 2'd3 && last_i) begin
                        st_d.run  = 1'b0;
                        st_d.lclk = 1'b0;
                    end else begin
                        st_d.lclk = 1'b1;
                    end
                end
            end else begin
                st_d.hcnt = st_q.hcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lnk_clk_o = st_q.lclk;
    assign ph_o      = st_q.ph;

    // a falling edge can only come from the high half
    assert_fall_from_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> lnk_clk_o);

    // a rising link clock always starts on a fresh half-period count
    assert_rise_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_clk_o) |-> (st_q.hcnt == '0) && !st_q.half);

endmodule

// File: rtl/tap2w_capture.sv
module tap2w_capture
    import tap2w_pkg::*;
#(
    parameter int IW = 5,
    parameter int DW = 32,
    parameter int LW = 37
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          din_i,
    input  tw_op_e        op_i,
    output logic [DW-1:0] data_o,
    output logic          flag_o,
    output logic          err_o
);

    localparam int OFF_MODE = LW - MODE_CYC;
    localparam int OFF_IR   = LW - (IR_HDR + IW + FOOT_CYC);
    localparam int OFF_DR   = LW - (DR_HDR + DW + FOOT_CYC);

    logic [LW-1:0] cap_d, cap_q;

    // samples enter at the top, so after N samples cycle k sits at LW-N+k
    always_comb begin
        cap_d = cap_q;
        if (clr_i)     cap_d = '0;
        else if (en_i) cap_d = {din_i, cap_q[LW-1:1]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    always_comb begin
        data_o = '0;
        flag_o = 1'b0;
        err_o  = 1'b0;
        case (op_i)
            OP_MODE: begin
                for (int k = 0; k < MODE_CYC; k++) err_o = err_o | cap_q[OFF_MODE + k];
            end
            OP_INSTR: begin
                for (int i = 0; i < IW; i++) data_o[i] = cap_q[OFF_IR + IR_HDR + i];
            end
            OP_DATA: begin
                for (int i = 0; i < DW; i++) data_o[i] = cap_q[OFF_DR + DR_HDR - 1 + i];
            end
            default: begin
                flag_o = cap_q[OFF_DR + DR_HDR - 1];
                for (int i = 0; i < DW; i++) data_o[i] = cap_q[OFF_DR + DR_HDR + i];
            end
        endcase
    end

    // capture never coincides with a new operation start
    assert_no_clr_during_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |-> !clr_i);

endmodule

// File: rtl/tap2w_master.sv
module tap2w_master
    import tap2w_pkg::*;
#(
    parameter int IW   = 5,
    parameter int DW   = 32,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_op,
    input  logic [DW-1:0]   req_bits,
    output logic            busy,
    output logic            done,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_flag,
    output logic            rsp_err,
    output logic            lnk_clk,
    output logic            lnk_dout,
    output logic            lnk_oe,
    input  logic            lnk_din
);

    localparam int LEN_IR = IR_HDR + IW + FOOT_CYC;
    localparam int LEN_DR = DR_HDR + DW + FOOT_CYC;
    localparam int LW_A   = (LEN_IR > LEN_DR) ? LEN_IR : LEN_DR;
    localparam int LW     = (LW_A > MODE_CYC) ? LW_A : MODE_CYC;
    localparam int CW     = $clog2(LW + 1);

    typedef struct packed {
        logic          busy;
        tw_op_e        op;
        logic [DW-1:0] bits;
        logic [CW-1:0] tc;
        logic          dout;
        logic          oe;
        logic          done;
        logic [DW-1:0] rdata;
        logic          rflag;
        logic          rerr;
    } mst_st_t;

    mst_st_t st_d, st_q;

    logic          start;
    logic          last;
    logic [1:0]    ph;
    logic          fall_evt;
    logic          end_evt;
    logic [31:0]   bits_req;
    logic [31:0]   bits_cur;
    logic [DW-1:0] cap_data;
    logic          cap_flag;
    logic          cap_err;
    int            len_cur;

    always_comb begin
        bits_req = '0;
        bits_req[DW-1:0] = req_bits;
        bits_cur = '0;
        bits_cur[DW-1:0] = st_q.bits;
    end

    assign start   = !st_q.busy && req_valid;
    assign len_cur = seq_len(st_q.op, IW, DW);
    assign last    = (int'(st_q.tc) == len_cur - 1);

    tap2w_phase #(.DIVW(DIVW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .div_i     (cfg_div),
        .last_i    (last),
        .lnk_clk_o (lnk_clk),
        .ph_o      (ph),
        .fall_o    (fall_evt),
        .end_o     (end_evt)
    );

    tap2w_capture #(.IW(IW), .DW(DW), .LW(LW)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start),
        .en_i   (st_q.busy && fall_evt && (ph == 2'd2)),
        .din_i  (lnk_din),
        .op_i   (st_q.op),
        .data_o (cap_data),
        .flag_o (cap_flag),
        .err_o  (cap_err)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.op   = tw_op_e'(req_op);
            st_d.bits = req_bits;
            st_d.tc   = '0;
            st_d.dout = seq_tdi(tw_op_e'(req_op), 0, IW, DW, bits_req);
            st_d.oe   = 1'b1;
        end else if (st_q.busy && end_evt) begin
            case (ph)
                2'd3: begin
                    if (last) begin
                        st_d.busy  = 1'b0;
                        st_d.done  = 1'b1;
                        st_d.dout  = 1'b0;
                        st_d.oe    = 1'b0;
                        st_d.rdata = cap_data;
                        st_d.rflag = cap_flag;
                        st_d.rerr  = cap_err;
                    end else begin
                        st_d.tc   = st_q.tc + 1'b1;
                        st_d.dout = seq_tdi(st_q.op, int'(st_q.tc) + 1, IW, DW, bits_cur);
                        st_d.oe   = 1'b1;
                    end
                end
                2'd0: begin
                    st_d.dout = seq_tms(st_q.op, int'(st_q.tc), IW, DW);
                    st_d.oe   = 1'b1;
                end
                default: begin
                    st_d.dout = 1'b0;
                    st_d.oe   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign rsp_data  = st_q.rdata;
    assign rsp_flag  = st_q.rflag;
    assign rsp_err   = st_q.rerr;
    assign lnk_dout  = st_q.dout;
    assign lnk_oe    = st_q.oe;

    assert_oe_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && ph[1]) |-> !lnk_oe);

    assert_oe_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !ph[1]) |-> lnk_oe);

    assert_stable_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lnk_clk) |-> ($stable(lnk_dout) && $stable(lnk_oe)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> (!lnk_clk && !lnk_oe && !lnk_dout));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_mode_tdi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.op == OP_MODE && ph == 2'd0) |-> !lnk_dout);

    assert_tc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (int'(st_q.tc) < len_cur));

endmodule

// File: tb/tap2w_master_test.sv
module tap2w_master_test;
    localparam int IW   = 5;
    localparam int DW   = 32;
    localparam int DIVW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DIVW-1:0] cfg_div = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_op = '0;
    logic [DW-1:0]   req_bits = '0;
    logic            busy, done;
    logic [DW-1:0]   rsp_data;
    logic            rsp_flag, rsp_err;
    logic            lnk_clk, lnk_dout, lnk_oe;
    logic            lnk_din = 1'b0;

    always #5 clk = ~clk;

    tap2w_master #(.IW(IW), .DW(DW), .DIVW(DIVW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_bits(req_bits),
        .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_flag(rsp_flag), .rsp_err(rsp_err),
        .lnk_clk(lnk_clk), .lnk_dout(lnk_dout), .lnk_oe(lnk_oe), .lnk_din(lnk_din)
    );

    int checks = 0, errors = 0;
    int mchecks = 0, merrors = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        mchecks++;
        if (!ok) begin
            merrors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- target model and link monitor ----------------
    logic [63:0] tdo_pat = '0;
    int          cur_div = 0;
    int          base = 0;
    int          rc = 0;
    int          cyc = 0;
    int          rise_t = 0;
    int          mp = 0, mt = 0;
    logic        prev = 1'b0;
    logic        dout_r = 1'b0, oe_r = 1'b0;
    logic        tdi_log [0:63];
    logic        tms_log [0:63];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            prev = 1'b0;
        end else begin
            if (lnk_clk && !prev) begin
                rc = rc + 1;
                mp = (rc - base - 1) % 4;
                mt = (rc - base - 1) / 4;
                if (rc - base > 1)
                    mchk(cyc - rise_t == 2 * (cur_div + 1), "R1 link clock period", cyc - rise_t, 2 * (cur_div + 1));
                rise_t = cyc;
                dout_r = lnk_dout;
                oe_r   = lnk_oe;
                mchk(lnk_oe == (mp < 2), "R2 data line enable for phase", lnk_oe, mp < 2);
                if (mt < 64) begin
                    if (mp == 2)      lnk_din = tdo_pat[mt];
                    else if (mp == 3) lnk_din = ~tdo_pat[mt];
                end
            end else if (!lnk_clk && prev) begin
                mchk(cyc - rise_t == cur_div + 1, "R1 link clock high time", cyc - rise_t, cur_div + 1);
                mchk(lnk_dout == dout_r && lnk_oe == oe_r, "R3 data stable across fall",
                     {lnk_dout, lnk_oe}, {dout_r, oe_r});
                if (mt < 64) begin
                    if (mp == 0) tdi_log[mt] = lnk_dout;
                    if (mp == 1) tms_log[mt] = lnk_dout;
                end
            end
            prev = lnk_clk;
        end
    end

    // ---------------- expected values from the requirements ----------------
    function automatic int e_len(input int op);
        if (op == 0) return 6;
        if (op == 1) return IW + 6;
        return DW + 5;
    endfunction

    function automatic logic e_tms(input int op, input int k);
        if (op == 0) return k < 5;
        if (op == 1) begin
            if (k < 2) return 1'b1;
            if (k < 4) return 1'b0;
            if (k < 4 + IW) return k == 3 + IW;
            return k == 4 + IW;
        end
        if (k == 0) return 1'b1;
        if (k < 3) return 1'b0;
        if (k < 3 + DW) return k == 2 + DW;
        return k == 3 + DW;
    endfunction

    function automatic logic e_tdi(input int op, input int k, input logic [DW-1:0] b);
        if (op == 1 && k >= 4 && k < 4 + IW) return b[k-4];
        if (op >= 2 && k >= 3 && k < 3 + DW) return b[k-3];
        return 1'b0;
    endfunction

    function automatic string tag(input int op);
        if (op == 0) return "R5";
        if (op == 1) return "R6";
        if (op == 2) return "R7";
        return "R8";
    endfunction

    task automatic run_op(input int op, input logic [DW-1:0] b, input int div,
                          input logic [63:0] pat, input bit poke);
        logic [DW-1:0] ed;
        logic          ef, ee;
        int            n, bad;
        @(negedge clk);
        cur_div   = div;
        cfg_div   = DIVW'(div);
        tdo_pat   = pat;
        base      = rc;
        req_op    = 2'(op);
        req_bits  = b;
        req_valid = 1'b1;
        chk(req_ready == 1'b1, "R9 ready while idle", req_ready, 1);
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy after accept", busy, 1);
        if (poke) begin
            req_op = 2'(op ^ 1);
            for (int i = 0; i < 4; i++) begin
                chk(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 done reached", done, 1);
        chk(busy == 1'b0, "R9 busy low with done", busy, 0);
        ed = '0; ef = 1'b0; ee = 1'b0;
        case (op)
            0: ee = |pat[5:0];
            1: for (int i = 0; i < IW; i++) ed[i] = pat[4 + i];
            2: for (int i = 0; i < DW; i++) ed[i] = pat[2 + i];
            default: begin
                ef = pat[2];
                for (int i = 0; i < DW; i++) ed[i] = pat[3 + i];
            end
        endcase
        chk(rc - base == 4 * e_len(op), {"R1 link clocks for ", tag(op)}, rc - base, 4 * e_len(op));
        bad = -1;
        for (int k = e_len(op) - 1; k >= 0; k--)
            if (tms_log[k] !== e_tms(op, k) || tdi_log[k] !== e_tdi(op, k, b)) bad = k;
        chk(bad == -1, {tag(op), " TMS/TDI sequence, first bad cycle"}, bad, 64'hFFFF_FFFF_FFFF_FFFF);
        chk(rsp_data == ed, {tag(op), " rsp_data (R4 sampling point)"}, rsp_data, ed);
        chk(rsp_flag == ef, {tag(op), " rsp_flag"}, rsp_flag, ef);
        chk(rsp_err == ee, {tag(op), " rsp_err"}, rsp_err, ee);
        @(negedge clk);
        chk(done == 1'b0, "R9 done is one cycle", done, 0);
        for (int i = 0; i < 3; i++) begin
            chk(busy == 1'b0 && !lnk_clk && !lnk_oe && !lnk_dout, "R10 idle outputs quiet",
                {busy, lnk_clk, lnk_oe, lnk_dout}, 0);
            @(negedge clk);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1500000;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrors + 1);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        chk(!lnk_clk && !lnk_oe && !lnk_dout, "R10 link quiet in reset", {lnk_clk, lnk_oe, lnk_dout}, 0);
        chk(!busy && !done, "R10 busy/done low in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

        // R5 mode: clean, TDO hit in last cycle, TDO only outside the window
        run_op(0, '0, 0, 64'h0, 1'b0);
        run_op(0, '0, 1, 64'h20, 1'b0);
        run_op(0, '0, 2, 64'hFFFF_FFC0, 1'b0);
        // R6 instruction: all ones, prologue TDO must be ignored
        run_op(1, 32'h1F, 1, 64'h8, 1'b0);
        run_op(1, 32'h0A, 0, 64'h1F0, 1'b0);
        // R7 data: prologue bit lands in LSB; final shift TDO ignored
        run_op(2, 32'h8000_0001, 0, 64'h4, 1'b0);
        run_op(2, 32'h0, 3, 64'h1 << (DW + 2), 1'b0);
        // R8 fast: flag clear and set, no retry
        run_op(3, 32'hDEAD_BEEF, 0, 64'h0000_000A_5A5A_5A58, 1'b0);
        run_op(3, 32'h1234_5678, 1, 64'h0000_0007_FFFF_FFFC, 1'b0);
        // R9 requests while busy are ignored
        run_op(2, 32'hA5A5_5A5A, 1, 64'h0000_0003_C3C3_3C3C, 1'b1);

        for (int i = 0; i < 28; i++) begin
            run_op(int'($urandom_range(3, 0)), DW'($urandom), int'($urandom_range(3, 0)),
                   {$urandom, $urandom}, ($urandom_range(3, 0) == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrors);
        $finish;
    end
endmodule